// File: doc/BRIEF.md
# Memory-Mapped Slave to Single-Port SRAM Bridge

This block lets a master on a reduced AXI-style slave port read and write a single-port synchronous SRAM, using as few registers as possible. The write side takes an address handshake and then a data handshake. It parks both in registers and issues them to the SRAM as one write cycle. The read side takes an address handshake and issues one SRAM read. One cycle later it registers the word the SRAM returns, and then presents that word with a one-cycle valid strobe.

The two channels run independently, so a write and a read can be in flight together. They share the one SRAM port through a two-way arbiter. When both channels want the port in the same cycle, the grant goes to the channel that did not win the most recent grant. The loser waits one cycle, and its READY stays low while it waits.

The port has no write response and no read-ready. Back-pressure works only towards the master: a channel holds its READY low while it is busy. The master cannot stall read data, so it must take RDATA in the cycle RVALID is high. Only one read and one write are ever outstanding.

Top module: `axi_sram_bridge`

## Requirements
- R1: While rst_n is low, aw_ready, w_ready, ar_ready, r_valid, mem_en and mem_we are all low. In the second cycle after reset is released, aw_ready and ar_ready are both high.
- R2: A write address is taken in a cycle with aw_valid and aw_ready both high. aw_ready is then low until the cycle after that address has been written to the SRAM.
- R3: w_ready is high only while a write address is held and its data has not yet been taken. Write data is captured in a cycle with w_valid and w_ready both high, and w_ready is low in the next cycle.
- R4: An uncontested write drives the SRAM for exactly one cycle, in the cycle after data capture. In that cycle mem_en=1 and mem_we=1, mem_addr equals the captured address (all bits) and mem_din equals the captured data.
- R5: An uncontested read drives the SRAM in the cycle after address acceptance. In that cycle mem_en=1, mem_we=0 and mem_addr equals the accepted ar_addr.
- R6: r_valid is high for exactly one cycle, two cycles after the read's SRAM cycle. In that cycle r_data holds the word the SRAM presented on mem_dout in the cycle after the read's SRAM cycle.
- R7: ar_ready is low from the cycle after a read address is accepted until the cycle after r_valid has pulsed, so at most one read is outstanding.
- R8: mem_en and mem_we are low in every cycle with no granted access, and mem_we is never high without mem_en.
- R9: When a pending write and a pending read both need the SRAM in the same cycle, the grant goes to the channel that did not win the most recent grant. If no grant has been made since reset, the write wins. The loser is granted in the very next cycle.
- R10: A write and a read to different addresses can be in flight at the same time. The read then returns the stored word and the write updates its location, whichever of the two is granted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_addr | input | ADDR_W | Write address |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | DATA_W | Write data |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_addr | input | ADDR_W | Read address |
| r_valid | output | 1 | Read data valid, one-cycle pulse, cannot be stalled |
| r_data | output | DATA_W | Read data |
| mem_en | output | 1 | SRAM enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | ADDR_W | SRAM address |
| mem_din | output | DATA_W | SRAM write data |
| mem_dout | input | DATA_W | SRAM read data, valid one cycle after a read cycle |

## Verification
Some rules are checked by the assertions on every cycle. Each address handshake closes its channel until the access finishes. Write-enable never appears without enable. A grant is only ever given to a requester. A channel that loses arbitration is served in the next cycle. r_valid is a single-cycle pulse that comes exactly two cycles after a read cycle. Only the bench's scenarios can show that the right address and data reach the SRAM and that read data match what was stored. They also show which channel wins a tie after each kind of history and the exact cycle in which each handshake reopens. For these the bench sweeps every location of a small SRAM model and runs concurrent pairs of transfers after both lone-read and lone-write histories.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  // write channel phases
  typedef enum logic [1:0] {
    WR_BOOT = 2'd0,   // held in reset, no handshake offered
    WR_IDLE = 2'd1,   // open for an address
    WR_DATA = 2'd2,   // address held, open for data
    WR_PEND = 2'd3    // address and data held, waiting for the SRAM
  } wr_state_e;

  // read channel phases
  typedef enum logic [2:0] {
    RD_BOOT = 3'd0,
    RD_IDLE = 3'd1,   // open for an address
    RD_PEND = 3'd2,   // address held, waiting for the SRAM
    RD_WAIT = 3'd3,   // SRAM read cycle done, word arrives now
    RD_RESP = 3'd4    // word registered, valid strobe out
  } rd_state_e;

endpackage

// File: rtl/bridge_wr_chan.sv
module bridge_wr_chan
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DATA_W-1:0] w_data,
  output logic              req,
  input  logic              gnt,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q
);

  wr_state_e state, state_nx;

  assign aw_ready = (state == WR_IDLE);
  assign w_ready  = (state == WR_DATA);
  assign req      = (state == WR_PEND);

  always_comb begin
    state_nx = state;
    unique case (state)
      WR_BOOT: state_nx = WR_IDLE;
      WR_IDLE: if (aw_valid) state_nx = WR_DATA;
      WR_DATA: if (w_valid)  state_nx = WR_PEND;
      WR_PEND: if (gnt)      state_nx = WR_IDLE;
      default: state_nx = WR_BOOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= WR_BOOT;
    else        state <= state_nx;
  end

  // payload registers need no reset: they are only read while req is high
  always_ff @(posedge clk) begin
    if (aw_valid && aw_ready) addr_q <= aw_addr;
    if (w_valid && w_ready)   data_q <= w_data;
  end

  AST_AW_CLOSES_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && aw_ready) |=> !aw_ready); // R2
  AST_AW_REOPENS_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aw_ready) |-> ($past(gnt) || $past(state == WR_BOOT))); // R2
  AST_W_ONLY_WITH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    w_ready |-> (!aw_ready && !req)); // R3
  AST_W_CLOSES_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (w_valid && w_ready) |=> (!w_ready && req)); // R3

endmodule

// File: rtl/bridge_rd_chan.sv
module bridge_rd_chan
  import bridge_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ADDR_W-1:0] ar_addr,
  output logic              req,
  input  logic              gnt,
  output logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] mem_dout,
  output logic              r_valid,
  output logic [DATA_W-1:0] r_data
);

  rd_state_e state, state_nx;

  assign ar_ready = (state == RD_IDLE);
  assign req      = (state == RD_PEND);
  assign r_valid  = (state == RD_RESP);

  always_comb begin
    state_nx = state;
    unique case (state)
      RD_BOOT: state_nx = RD_IDLE;
      RD_IDLE: if (ar_valid) state_nx = RD_PEND;
      RD_PEND: if (gnt)      state_nx = RD_WAIT;
      RD_WAIT: state_nx = RD_RESP;
      RD_RESP: state_nx = RD_IDLE;
      default: state_nx = RD_BOOT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= RD_BOOT;
    else        state <= state_nx;
  end

  always_ff @(posedge clk) begin
    if (ar_valid && ar_ready) addr_q <= ar_addr;
    if (state == RD_WAIT)     r_data <= mem_dout;
  end

  AST_AR_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_ready) |=> !ar_ready); // R7
  AST_AR_CLOSED_DURING_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> !ar_ready); // R7
  AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |=> !r_valid); // R6

endmodule

// File: rtl/bridge_arb.sv
module bridge_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic req_w,
  input  logic req_r,
  output logic gnt_w,
  output logic gnt_r
);

  // 1 when the most recent grant went to the write channel
  logic last_w;

  assign gnt_w = req_w && (!req_r || !last_w);
  assign gnt_r = req_r && (!req_w ||  last_w);

  always_ff @(posedge clk) begin
    if (!rst_n)     last_w <= 1'b0;
    else if (gnt_w) last_w <= 1'b1;
    else if (gnt_r) last_w <= 1'b0;
  end

  AST_GNT_W_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_w |-> req_w); // R8
  AST_GNT_R_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_r |-> req_r); // R8
  AST_W_NOT_STARVED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_w && !gnt_w) |=> gnt_w); // R9
  AST_R_NOT_STARVED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_r && !gnt_r) |=> gnt_r); // R9

endmodule

// File: rtl/axi_sram_bridge.sv
module axi_sram_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic              ar_valid,
  output logic              ar_ready,
  input  logic [ADDR_W-1:0] ar_addr,
  output logic              r_valid,
  output logic [DATA_W-1:0] r_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_din,
  input  logic [DATA_W-1:0] mem_dout
);

  logic              wr_req, wr_gnt, rd_req, rd_gnt;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data;

  bridge_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .aw_valid (aw_valid),
    .aw_ready (aw_ready),
    .aw_addr  (aw_addr),
    .w_valid  (w_valid),
    .w_ready  (w_ready),
    .w_data   (w_data),
    .req      (wr_req),
    .gnt      (wr_gnt),
    .addr_q   (wr_addr),
    .data_q   (wr_data)
  );

  bridge_rd_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ar_valid (ar_valid),
    .ar_ready (ar_ready),
    .ar_addr  (ar_addr),
    .req      (rd_req),
    .gnt      (rd_gnt),
    .addr_q   (rd_addr),
    .mem_dout (mem_dout),
    .r_valid  (r_valid),
    .r_data   (r_data)
  );

  bridge_arb u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req_w (wr_req),
    .req_r (rd_req),
    .gnt_w (wr_gnt),
    .gnt_r (rd_gnt)
  );

  // SRAM port: driven only by the granted channel, quiet otherwise
  always_comb begin
    mem_en   = wr_gnt || rd_gnt;
    mem_we   = wr_gnt;
    mem_addr = '0;
    mem_din  = '0;
    if (wr_gnt) begin
      mem_addr = wr_addr;
      mem_din  = wr_data;
    end else if (rd_gnt) begin
      mem_addr = rd_addr;
    end
  end

  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en); // R8
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> $past(mem_en && !mem_we, 2)); // R6
  AST_READ_BLOCKS_AR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> !ar_ready); // R7

endmodule

// File: tb/sim_axi_sram_bridge.sv
`timescale 1ns/1ps
module sim_axi_sram_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aw_valid = 1'b0, w_valid = 1'b0, ar_valid = 1'b0;
  logic [31:0] aw_addr = '0, w_data = '0, ar_addr = '0;
  logic        aw_ready, w_ready, ar_ready, r_valid;
  logic [31:0] r_data;
  logic        mem_en, mem_we;
  logic [31:0] mem_addr, mem_din;
  logic [31:0] mem_dout;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] ram [16];
  logic [31:0] exp_mem [16];
  logic last_w_m;     // bench record of the most recent grant (1 = write)
  logic we_alone;     // mem_we ever seen without mem_en

  always #4 clk = ~clk;   // 125 MHz

  axi_sram_bridge u0 (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
    .r_valid(r_valid), .r_data(r_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_din(mem_din), .mem_dout(mem_dout)
  );

  // 16-word synchronous SRAM, word index from address bits [5:2]
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr[5:2]] <= mem_din;
      else        mem_dout <= ram[mem_addr[5:2]];
    end
  end

  always @(posedge clk) begin
    if (!rst_n) last_w_m <= 1'b0;
    else if (mem_en) last_w_m <= mem_we;
  end

  initial we_alone = 1'b0;
  always @(negedge clk) if (rst_n && mem_we && !mem_en) we_alone = 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int salt);
    return (32'h9E3779B9 * (i + 1)) ^ (32'h01010101 * salt) ^ 32'(i);
  endfunction

  // called at a negedge with the channel idle; returns at a negedge
  task automatic do_write(input int idx, input logic [31:0] data);
    logic [31:0] a;
    a = (32'h0100_0000 * idx) | (idx << 2);
    aw_valid = 1'b1; aw_addr = a;
    chk(aw_ready, "R2 aw_ready open", {31'd0, aw_ready}, 32'd1);
    @(negedge clk);
    aw_valid = 1'b0;
    chk(!aw_ready, "R2 aw_ready closed", {31'd0, aw_ready}, 32'd0);
    chk(w_ready, "R3 w_ready with addr", {31'd0, w_ready}, 32'd1);
    w_valid = 1'b1; w_data = data;
    @(negedge clk);
    w_valid = 1'b0;
    chk(!w_ready, "R3 w_ready after data", {31'd0, w_ready}, 32'd0);
    chk(mem_en && mem_we, "R4 write strobes", {30'd0, mem_en, mem_we}, 32'd3);
    chk(mem_addr == a, "R4 write addr", mem_addr, a);
    chk(mem_din == data, "R4 write data", mem_din, data);
    exp_mem[idx] = data;
    @(negedge clk);
    chk(aw_ready, "R2 aw_ready reopens", {31'd0, aw_ready}, 32'd1);
    chk(!mem_en && !mem_we, "R8 idle after write", {30'd0, mem_en, mem_we}, 32'd0);
  endtask

  task automatic do_read(input int idx);
    logic [31:0] a;
    a = (32'h0010_0000 * (15 - idx)) | (idx << 2);
    ar_valid = 1'b1; ar_addr = a;
    chk(ar_ready, "R7 ar_ready open", {31'd0, ar_ready}, 32'd1);
    @(negedge clk);
    ar_valid = 1'b0;
    chk(mem_en && !mem_we, "R5 read strobes", {30'd0, mem_en, mem_we}, 32'd2);
    chk(mem_addr == a, "R5 read addr", mem_addr, a);
    chk(!ar_ready, "R7 ar_ready closed", {31'd0, ar_ready}, 32'd0);
    @(negedge clk);
    chk(!r_valid, "R6 no early valid", {31'd0, r_valid}, 32'd0);
    chk(!mem_en, "R8 idle during read wait", {31'd0, mem_en}, 32'd0);
    @(negedge clk);
    chk(r_valid, "R6 valid pulse", {31'd0, r_valid}, 32'd1);
    chk(r_data == exp_mem[idx], "R6 read data", r_data, exp_mem[idx]);
    chk(!ar_ready, "R7 closed during valid", {31'd0, ar_ready}, 32'd0);
    @(negedge clk);
    chk(!r_valid, "R6 pulse ends", {31'd0, r_valid}, 32'd0);
    chk(ar_ready, "R7 ar_ready reopens", {31'd0, ar_ready}, 32'd1);
  endtask

  // write to widx and read from ridx with both requests meeting at the arbiter
  task automatic do_tie(input int widx, input int ridx, input logic [31:0] data);
    logic        first_w;
    logic [31:0] rexp;
    int          g_r;
    aw_valid = 1'b1; aw_addr = widx << 2;
    @(negedge clk);
    aw_valid = 1'b0;
    w_valid = 1'b1; w_data = data;
    ar_valid = 1'b1; ar_addr = ridx << 2;
    chk(ar_ready, "R10 ar_ready while write open", {31'd0, ar_ready}, 32'd1);
    @(negedge clk);
    w_valid = 1'b0; ar_valid = 1'b0;
    first_w = !last_w_m;
    rexp = exp_mem[ridx];
    chk(mem_en && (mem_we == first_w), "R9 tie winner",
        {30'd0, mem_en, mem_we}, {30'd0, 1'b1, first_w});
    chk(!aw_ready && !ar_ready, "R9 loser held", {30'd0, aw_ready, ar_ready}, 32'd0);
    @(negedge clk);
    chk(mem_en && (mem_we == !first_w), "R9 loser next cycle",
        {30'd0, mem_en, mem_we}, {30'd0, 1'b1, !first_w});
    exp_mem[widx] = data;
    g_r = first_w ? 1 : 0;
    for (int c = 2; c <= 3; c++) begin
      @(negedge clk);
      chk(r_valid == (c == g_r + 2), "R10 valid timing", {31'd0, r_valid}, {31'd0, c == g_r + 2});
      if (c == g_r + 2) chk(r_data == rexp, "R10 concurrent read data", r_data, rexp);
    end
    @(negedge clk);
    chk(aw_ready && ar_ready, "R10 both reopen", {30'd0, aw_ready, ar_ready}, 32'd3);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({aw_ready, w_ready, ar_ready, r_valid, mem_en, mem_we} == 6'd0, "R1 reset outputs",
        {26'd0, aw_ready, w_ready, ar_ready, r_valid, mem_en, mem_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(aw_ready && ar_ready, "R1 ready after reset", {30'd0, aw_ready, ar_ready}, 32'd3);
    chk(!w_ready && !r_valid, "R1 others quiet", {30'd0, w_ready, r_valid}, 32'd0);

    // sweep every location, read back in reverse
    for (int i = 0; i < 16; i++) do_write(i, pat(i, 0));
    for (int i = 15; i >= 0; i--) do_read(i);
    // overwrite every other location, read all again
    for (int i = 0; i < 16; i += 2) do_write(i, pat(i, 7));
    for (int i = 0; i < 16; i++) do_read(i);

    // idle cycles: no SRAM activity
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!mem_en && !mem_we, "R8 idle port", {30'd0, mem_en, mem_we}, 32'd0);
    end

    // concurrent pairs after alternating histories
    for (int k = 0; k < 8; k++) begin
      if (k % 2 == 0) do_read(k);
      else            do_write(k, pat(k, 3));
      do_tie(k, (k + 8) % 16, pat(k, 11));
    end
    // confirm concurrent writes landed
    for (int k = 0; k < 8; k++) do_read(k);

    chk(!we_alone, "R8 we without en", {31'd0, we_alone}, 32'd0);
    finish_run();
  end

endmodule